// File: doc/BRIEF.md
# Reservation Monitor for Paired Reserve/Conditional-Store Accesses

This block places a small word-addressed memory between two harts and tracks, for each hart, one reservation used by reserve-then-conditional-store sequences. A reserving load returns the addressed word and remembers the aligned granule (a group of bytes wider than one word) that holds it. A later conditional store from the same hart writes only while that reservation is still live and covers the same granule. It answers 0 when it writes and 1 when it does not. Because a whole granule is tracked, a store by the other hart to a neighbouring word in the granule also makes the conditional store fail.

Each hart has its own request port carrying an operation code, a byte address, write data and an interrupt line that drops its reservation. Both ports may issue in the same cycle. The two requests are then handled as if hart 0 went first: hart 1 sees hart 0's write, both in its read data and in its reservation check. Every request gets a response one cycle later.

Top module: `llsc_monitor`

## Requirements
- R1: After reset every hart holds no reservation, every memory word reads 0, and no response is valid while reset is held.
- R2: Operation codes are 0 plain load, 1 plain store, 2 reserving load, 3 conditional store. Address bits [1:0] are ignored and bits [5:2] select the word. A request in one cycle raises the response-valid output in the next cycle. Loads and reserving loads then return the word. Stores return 0.
- R3: A conditional store whose hart holds a live reservation on the same 16-byte granule (address bits [5:4]) writes its data and returns 0.
- R4: A conditional store fails with result 1 and leaves memory unchanged in two cases: its hart holds no reservation, or the reservation is on a different granule.
- R5: Every conditional store drops its own hart's reservation, whether it succeeds or fails.
- R6: A write by the other hart (a plain store or a successful conditional store) to any word of the reserved granule drops the reservation. A write to another granule leaves it live.
- R7: A hart's own plain store does not drop its own reservation.
- R8: A new reserving load replaces the hart's earlier reservation.
- R9: A hart's interrupt input drops its reservation. A conditional store in the same cycle therefore fails, while a reserving load in the same cycle still sets a new reservation.
- R10: Same-cycle requests resolve hart 0 first. Hart 1 reads hart 0's new data. Hart 0 reads the old data under hart 1's store. A write by hart 0 makes hart 1's conditional store to that granule fail. When both write one word, hart 1's data remains.
- R11: With no interference, a reserving load followed by a conditional store from the same hart always succeeds, so a retried sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h0_req | input | 1 | Hart 0 request valid |
| h0_op | input | 2 | Hart 0 operation code |
| h0_addr | input | 6 | Hart 0 byte address |
| h0_wdata | input | 32 | Hart 0 store data |
| h0_irq | input | 1 | Hart 0 interrupt, drops its reservation |
| h0_rsp_valid | output | 1 | Hart 0 response valid |
| h0_rdata | output | 32 | Hart 0 read data or conditional-store result |
| h1_req | input | 1 | Hart 1 request valid |
| h1_op | input | 2 | Hart 1 operation code |
| h1_addr | input | 6 | Hart 1 byte address |
| h1_wdata | input | 32 | Hart 1 store data |
| h1_irq | input | 1 | Hart 1 interrupt, drops its reservation |
| h1_rsp_valid | output | 1 | Hart 1 response valid |
| h1_rdata | output | 32 | Hart 1 read data or conditional-store result |

## Verification
Every response, whether a read word, a store acknowledgement or a conditional-store result, is due exactly one clock edge after the request is presented. A memory write or reservation change becomes visible to the next request, or within the same cycle to hart 1. The bench drives each request just after a rising edge and advances its reference model at the following edge. It then compares both response ports one time unit after that edge, so every comparison lands on the cycle whose result the model predicts. Directed sequences cover each reservation-dropping case and each same-cycle ordering, and a randomized run follows.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD    = 2'd0,
        OP_STORE   = 2'd1,
        OP_RESERVE = 2'd2,
        OP_COND    = 2'd3
    } llsc_op_e;

    typedef enum logic [1:0] {
        RSP_MEM,
        RSP_ZERO,
        RSP_FAIL
    } rsp_src_e;

    function automatic logic op_writes(input llsc_op_e op, input logic cond_pass);
        return (op == OP_STORE) || ((op == OP_COND) && cond_pass);
    endfunction

    function automatic rsp_src_e rsp_source(input llsc_op_e op, input logic cond_pass);
        unique case (op)
            OP_LOAD, OP_RESERVE: return RSP_MEM;
            OP_STORE:            return RSP_ZERO;
            default:             return cond_pass ? RSP_ZERO : RSP_FAIL;
        endcase
    endfunction

endpackage

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
    parameter int GRAN_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq,
    input  logic              req_lr,
    input  logic              req_sc,
    input  logic [GRAN_W-1:0] gran,
    input  logic              pre_en,
    input  logic [GRAN_W-1:0] pre_gran,
    input  logic              post_en,
    input  logic [GRAN_W-1:0] post_gran,
    output logic              sc_pass,
    output logic              valid_q,
    output logic [GRAN_W-1:0] tag_q
);
    logic              live;
    logic              nxt_valid;
    logic [GRAN_W-1:0] nxt_tag;

    always_comb begin
        live    = valid_q && !irq && !(pre_en && (pre_gran == tag_q));
        sc_pass = req_sc && live && (tag_q == gran);
        nxt_tag = tag_q;
        if (req_lr) begin
            nxt_valid = 1'b1;
            nxt_tag   = gran;
        end else if (req_sc) begin
            nxt_valid = 1'b0;
        end else begin
            nxt_valid = live;
        end
        if (post_en && (post_gran == nxt_tag)) nxt_valid = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else begin
            valid_q <= nxt_valid;
            tag_q   <= nxt_tag;
        end
    end

    a_r5_sc_drops: assert property (@(posedge clk) disable iff (rst)
        (req_sc && !req_lr) |=> !valid_q);
    a_r9_irq_drops: assert property (@(posedge clk) disable iff (rst)
        (irq && !req_lr) |=> !valid_q);
    a_r8_lr_sets: assert property (@(posedge clk) disable iff (rst)
        (req_lr && !post_en) |=> (valid_q && (tag_q == $past(gran))));
    a_r6_foreign_drop: assert property (@(posedge clk) disable iff (rst)
        (pre_en && valid_q && (pre_gran == tag_q) && !req_lr) |=> !valid_q);

endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
    parameter int DATA_W      = 32,
    parameter int DEPTH_WORDS = 16,
    localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we0,
    input  logic [IDX_W-1:0]  wa0,
    input  logic [DATA_W-1:0] wd0,
    input  logic              we1,
    input  logic [IDX_W-1:0]  wa1,
    input  logic [DATA_W-1:0] wd1,
    input  logic [IDX_W-1:0]  ra0,
    input  logic [IDX_W-1:0]  ra1,
    output logic [DATA_W-1:0] rd0,
    output logic [DATA_W-1:0] rd1
);
    logic [DATA_W-1:0] mem_q [DEPTH_WORDS];

    for (genvar i = 0; i < DEPTH_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)                                 mem_q[i] <= '0;
            else if (we1 && (wa1 == IDX_W'(i)))      mem_q[i] <= wd1;
            else if (we0 && (wa0 == IDX_W'(i)))      mem_q[i] <= wd0;
        end
    end

    assign rd0 = mem_q[ra0];
    assign rd1 = (we0 && (wa0 == ra1)) ? wd0 : mem_q[ra1];

    a_r10_later_wins: assert property (@(posedge clk) disable iff (rst)
        (we0 && we1 && (wa0 == wa1)) |=> (mem_q[$past(wa1)] == $past(wd1)));

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int DEPTH_WORDS = 16,
    parameter int GRAN_BYTES  = 16,
    localparam int ADDR_W     = $clog2(DEPTH_WORDS * (DATA_W / 8))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h0_req,
    input  logic [1:0]        h0_op,
    input  logic [ADDR_W-1:0] h0_addr,
    input  logic [DATA_W-1:0] h0_wdata,
    input  logic              h0_irq,
    output logic              h0_rsp_valid,
    output logic [DATA_W-1:0] h0_rdata,
    input  logic              h1_req,
    input  logic [1:0]        h1_op,
    input  logic [ADDR_W-1:0] h1_addr,
    input  logic [DATA_W-1:0] h1_wdata,
    input  logic              h1_irq,
    output logic              h1_rsp_valid,
    output logic [DATA_W-1:0] h1_rdata
);
    localparam int WORD_LSB = $clog2(DATA_W / 8);
    localparam int IDX_W    = $clog2(DEPTH_WORDS);
    localparam int GRAN_LSB = $clog2(GRAN_BYTES);
    localparam int GRAN_W   = ADDR_W - GRAN_LSB;

    llsc_op_e          op0, op1;
    logic [IDX_W-1:0]  idx0, idx1;
    logic [GRAN_W-1:0] gr0, gr1;
    logic              pass0, pass1, wr0, wr1;
    logic              rv0, rv1;
    logic [GRAN_W-1:0] rt0, rt1;
    logic [DATA_W-1:0] md0, md1;

    assign op0  = llsc_op_e'(h0_op);
    assign op1  = llsc_op_e'(h1_op);
    assign idx0 = h0_addr[WORD_LSB +: IDX_W];
    assign idx1 = h1_addr[WORD_LSB +: IDX_W];
    assign gr0  = h0_addr[ADDR_W-1:GRAN_LSB];
    assign gr1  = h1_addr[ADDR_W-1:GRAN_LSB];
    assign wr0  = h0_req && op_writes(op0, pass0);
    assign wr1  = h1_req && op_writes(op1, pass1);

    llsc_resv_slot #(.GRAN_W(GRAN_W)) u_slot0 (
        .clk(clk), .rst(rst), .irq(h0_irq),
        .req_lr(h0_req && op0 == OP_RESERVE), .req_sc(h0_req && op0 == OP_COND),
        .gran(gr0), .pre_en(1'b0), .pre_gran('0),
        .post_en(wr1), .post_gran(gr1),
        .sc_pass(pass0), .valid_q(rv0), .tag_q(rt0)
    );

    llsc_resv_slot #(.GRAN_W(GRAN_W)) u_slot1 (
        .clk(clk), .rst(rst), .irq(h1_irq),
        .req_lr(h1_req && op1 == OP_RESERVE), .req_sc(h1_req && op1 == OP_COND),
        .gran(gr1), .pre_en(wr0), .pre_gran(gr0),
        .post_en(1'b0), .post_gran('0),
        .sc_pass(pass1), .valid_q(rv1), .tag_q(rt1)
    );

    llsc_mem #(.DATA_W(DATA_W), .DEPTH_WORDS(DEPTH_WORDS)) u_mem (
        .clk(clk), .rst(rst),
        .we0(wr0), .wa0(idx0), .wd0(h0_wdata),
        .we1(wr1), .wa1(idx1), .wd1(h1_wdata),
        .ra0(idx0), .ra1(idx1), .rd0(md0), .rd1(md1)
    );

    function automatic logic [DATA_W-1:0] pick(input rsp_src_e s, input logic [DATA_W-1:0] m);
        unique case (s)
            RSP_MEM:  return m;
            RSP_FAIL: return DATA_W'(1);
            default:  return '0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            h0_rsp_valid <= 1'b0;
            h1_rsp_valid <= 1'b0;
            h0_rdata     <= '0;
            h1_rdata     <= '0;
        end else begin
            h0_rsp_valid <= h0_req;
            h1_rsp_valid <= h1_req;
            if (h0_req) h0_rdata <= pick(rsp_source(op0, pass0), md0);
            if (h1_req) h1_rdata <= pick(rsp_source(op1, pass1), md1);
        end
    end

    a_r2_rsp_h0: assert property (@(posedge clk) disable iff (rst)
        h0_req |=> h0_rsp_valid);
    a_r2_rsp_h1: assert property (@(posedge clk) disable iff (rst)
        h1_req |=> h1_rsp_valid);
    a_r4_no_resv_fails: assert property (@(posedge clk) disable iff (rst)
        (h0_req && op0 == OP_COND && !rv0) |=> (h0_rdata == DATA_W'(1)));
    a_r10_h1_after_h0: assert property (@(posedge clk) disable iff (rst)
        (wr0 && h1_req && op1 == OP_COND && rv1 && rt1 == gr0) |=> (h1_rdata == DATA_W'(1)));

endmodule

// File: tb/llsc_monitor_bench.sv
`timescale 1ns/1ps
module llsc_monitor_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        q0, q1, i0, i1;
    logic [1:0]  o0, o1;
    logic [5:0]  a0, a1;
    logic [31:0] d0, d1;
    logic        v0, v1;
    logic [31:0] r0, r1;

    llsc_monitor u_llsc_monitor (
        .clk(clk), .rst(rst),
        .h0_req(q0), .h0_op(o0), .h0_addr(a0), .h0_wdata(d0), .h0_irq(i0),
        .h0_rsp_valid(v0), .h0_rdata(r0),
        .h1_req(q1), .h1_op(o1), .h1_addr(a1), .h1_wdata(d1), .h1_irq(i1),
        .h1_rsp_valid(v1), .h1_rdata(r1)
    );

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    logic [31:0] mm [16];
    bit          rv [2];
    int          rt [2];
    bit          ev [2];
    logic [31:0] ed [2];

    task automatic model_reset();
        for (int k = 0; k < 16; k++) mm[k] = '0;
        rv[0] = 0; rv[1] = 0; ev[0] = 0; ev[1] = 0;
    endtask

    task automatic model_one(input int h, input bit q, input logic [1:0] op,
                             input logic [5:0] ad, input logic [31:0] wd);
        int g, w, other;
        g = int'(ad) >> 4; w = (int'(ad) >> 2) & 15; other = 1 - h;
        ev[h] = q;
        if (!q) return;
        case (op)
            2'd0: ed[h] = mm[w];
            2'd1: begin
                mm[w] = wd; ed[h] = 0;
                if (rv[other] && rt[other] == g) rv[other] = 0;
            end
            2'd2: begin ed[h] = mm[w]; rv[h] = 1; rt[h] = g; end
            default: begin
                if (rv[h] && rt[h] == g) begin
                    mm[w] = wd; ed[h] = 0;
                    if (rv[other] && rt[other] == g) rv[other] = 0;
                end else ed[h] = 1;
                rv[h] = 0;
            end
        endcase
    endtask

    task automatic check(input string tag);
        vectors++;
        if (v0 !== ev[0] || (ev[0] && r0 !== ed[0])) begin
            misses++;
            $display("FAIL %s hart0: valid=%0b data=%h expected valid=%0b data=%h", tag, v0, r0, ev[0], ed[0]);
        end
        vectors++;
        if (v1 !== ev[1] || (ev[1] && r1 !== ed[1])) begin
            misses++;
            $display("FAIL %s hart1: valid=%0b data=%h expected valid=%0b data=%h", tag, v1, r1, ev[1], ed[1]);
        end
    endtask

    task automatic cyc(input string tag,
                       input bit rq0, input logic [1:0] op0, input logic [5:0] ad0, input logic [31:0] w0, input bit ir0,
                       input bit rq1, input logic [1:0] op1, input logic [5:0] ad1, input logic [31:0] w1, input bit ir1);
        q0 = rq0; o0 = op0; a0 = ad0; d0 = w0; i0 = ir0;
        q1 = rq1; o1 = op1; a1 = ad1; d1 = w1; i1 = ir1;
        @(posedge clk);
        if (ir0) rv[0] = 0;
        if (ir1) rv[1] = 0;
        model_one(0, rq0, op0, ad0, w0);
        model_one(1, rq1, op1, ad1, w1);
        #1;
        check(tag);
    endtask

    task automatic h0(input string tag, input logic [1:0] op, input logic [5:0] ad, input logic [31:0] w, input bit ir = 0);
        cyc(tag, 1, op, ad, w, ir, 0, 2'd0, 6'd0, 0, 0);
    endtask

    task automatic h1(input string tag, input logic [1:0] op, input logic [5:0] ad, input logic [31:0] w, input bit ir = 0);
        cyc(tag, 0, 2'd0, 6'd0, 0, 0, 1, op, ad, w, ir);
    endtask

    localparam logic [1:0] LD = 2'd0, ST = 2'd1, LR = 2'd2, SC = 2'd3;

    initial begin
        #150000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        q0 = 0; q1 = 0; i0 = 0; i1 = 0; o0 = 0; o1 = 0; a0 = 0; a1 = 0; d0 = 0; d1 = 0;
        model_reset();
        repeat (2) @(posedge clk);
        #1;
        check("R1");
        rst = 1'b0;
        // R1: no reservation and zero memory after reset
        h0("R1", SC, 6'h00, 32'hdead_0001);
        h0("R1", LD, 6'h00, 0);
        h1("R1", LD, 6'h3c, 0);
        // R2: plain store and loads, low address bits ignored
        h0("R2", ST, 6'h04, 32'h1111_aaaa);
        h0("R2", LD, 6'h07, 0);
        h1("R2", LD, 6'h04, 0);
        // R3 / R11: reserve then conditional store succeeds
        h0("R3", LR, 6'h04, 0);
        h0("R3", SC, 6'h04, 32'h2222_bbbb);
        h0("R3", LD, 6'h04, 0);
        // R4: conditional store to another granule fails, no write
        h0("R4", LR, 6'h10, 0);
        h0("R4", SC, 6'h20, 32'h3333_cccc);
        h0("R4", LD, 6'h20, 0);
        // R5: second conditional store fails
        h1("R5", LR, 6'h20, 0);
        h1("R5", SC, 6'h20, 32'h4444_dddd);
        h1("R5", SC, 6'h20, 32'h5555_eeee);
        h1("R5", LD, 6'h20, 0);
        // R6: foreign store to neighbour word kills, other granule does not
        h0("R6", LR, 6'h30, 0);
        h1("R6", ST, 6'h3c, 32'h6666_0000);
        h0("R6", SC, 6'h30, 32'h6666_1111);
        h0("R6", LR, 6'h30, 0);
        h1("R6", ST, 6'h24, 32'h6666_2222);
        h0("R6", SC, 6'h30, 32'h6666_3333);
        // R7: own store keeps own reservation
        h0("R7", LR, 6'h00, 0);
        h0("R7", ST, 6'h08, 32'h7777_0000);
        h0("R7", SC, 6'h00, 32'h7777_1111);
        // R8: new reservation replaces old
        h1("R8", LR, 6'h10, 0);
        h1("R8", LR, 6'h30, 0);
        h1("R8", SC, 6'h10, 32'h8888_0000);
        h1("R8", LR, 6'h10, 0);
        h1("R8", LR, 6'h30, 0);
        h1("R8", SC, 6'h30, 32'h8888_1111);
        // R9: interrupts
        h0("R9", LR, 6'h00, 0);
        cyc("R9", 0, LD, 0, 0, 1, 0, LD, 0, 0, 0);
        h0("R9", SC, 6'h00, 32'h9999_0000);
        h1("R9", LR, 6'h10, 0);
        h1("R9", SC, 6'h10, 32'h9999_1111, 1);
        h0("R9", LR, 6'h00, 0, 1);
        h0("R9", SC, 6'h00, 32'h9999_2222);
        // R10: same-cycle ordering
        cyc("R10", 1, ST, 6'h14, 32'haaaa_0001, 0, 1, LD, 6'h14, 0, 0);
        cyc("R10", 1, LD, 6'h18, 0, 0, 1, ST, 6'h18, 32'haaaa_0002, 0);
        cyc("R10", 1, LR, 6'h20, 0, 0, 1, LR, 6'h28, 0, 0);
        cyc("R10", 1, SC, 6'h20, 32'haaaa_0003, 0, 1, SC, 6'h28, 32'haaaa_0004, 0);
        cyc("R10", 1, LD, 6'h20, 0, 0, 1, LD, 6'h28, 0, 0);
        cyc("R10", 1, ST, 6'h24, 32'haaaa_0005, 0, 1, ST, 6'h24, 32'haaaa_0006, 0);
        h0("R10", LD, 6'h24, 0);
        cyc("R10", 1, LR, 6'h00, 0, 0, 1, LR, 6'h30, 0, 0);
        cyc("R10", 1, ST, 6'h34, 32'haaaa_0007, 0, 1, SC, 6'h30, 32'haaaa_0008, 0);
        h1("R10", LD, 6'h30, 0);
        // R11: uncontended retry loop succeeds
        h1("R11", LR, 6'h08, 0);
        h1("R11", SC, 6'h08, 32'hbbbb_0001);
        // mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] rnd;
            rnd = $urandom;
            cyc("R10", rnd[0], rnd[2:1], {rnd[6:3], 2'b00}, $urandom, rnd[7] & rnd[8] & rnd[9],
                       rnd[10], rnd[12:11], {rnd[16:13], 2'b00}, $urandom, rnd[17] & rnd[18] & rnd[19]);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule